// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Hazard Unit

This block sits beside the decode stage of a five-stage, in-order pipeline with eight registers and 25-bit instruction words. It decodes the decoding instruction's source fields and compares them against the destination tags of the three younger-than-retired producers: the decode/execute, execute/memory and memory/writeback pipeline registers. From that comparison it derives a hazard class and a forwarding position for each ALU operand. It registers both into the execute stage. One cycle later it uses them to pick each operand from the execute/memory ALU result, the memory/writeback write data, the post-writeback latch, or the register file value read in decode.

A destination tag equal to 8 stands for "writes no register". Because every source field is three bits wide, that tag can never match a source, so the block needs no separate valid bit. When the instruction in execute is a load and its destination feeds a used source of the decoding instruction, the block holds fetch and decode for one cycle and requests a bubble into execute. After that cycle the load result is one stage further on and is forwarded from memory/writeback.

A two-state flow controller guards the stall. `FL_RUN` is the normal state. The transition `FL_RUN -> FL_BUBBLE` happens on a load-use stall. The transition `FL_BUBBLE -> FL_RUN` is unconditional after one cycle. While in `FL_RUN` with no load-use stall, the controller stays in `FL_RUN`.

Top module: `hz_fwd_unit`

## Requirements
- R1: The opcode is instruction bits 24:22, source A is bits 21:19 and source B is bits 18:16. Source A is used by every opcode except halt (6) and noop (7). Source B is used only by add (0), nand (1), sw (3), beq (4) and mult (5), and is ignored for lw (2).
- R2: `dec_dest` is instruction bits 2:0 for add, nand and mult, and bits 18:16 for lw. It is 8 for sw, beq, halt and noop.
- R3: `hz_class` is 0 when no used source matches a tag, 1 when only A matches, 2 when only B matches and 3 when both match. A tag of 8 never matches.
- R4: When several stages hold the matching tag, the youngest wins. Decode/execute is position 0, then execute/memory is position 1, then memory/writeback is position 2.
- R5: On each clock, `ex_class`, `ex_pos_a` and `ex_pos_b` take the class and positions computed in decode. Position code 3 (the two-bit form of -1) means the register file supplies the operand.
- R6: `ex_opnd_a`/`ex_opnd_b` equal `res_exmem` for position 0, `res_memwb` for position 1 and `res_wbend` for position 2. For position 3 they equal the `rf_a`/`rf_b` value registered at the last clock.
- R7: A load-use stall occurs when `ex_is_load` is high and `tag_idex` matches a used source. It is only possible in `FL_RUN`. In that cycle `hz_class` is 4 and `stall` and `bubble_ex` are high. After the next clock, `ex_class` is 4 and both positions are 3.
- R8: In the cycle right after a stall, no stall is raised and `hz_class` is never 4, even if a load with a matching tag is presented.
- R9: After reset, `ex_class` is 0, both positions are 3 and both forwarded operands are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_instr | input | 25 | Instruction in decode |
| ex_is_load | input | 1 | Instruction in execute is a load |
| tag_idex | input | 4 | Destination tag in decode/execute register |
| tag_exmem | input | 4 | Destination tag in execute/memory register |
| tag_memwb | input | 4 | Destination tag in memory/writeback register |
| res_exmem | input | DATA_W | ALU result in execute/memory |
| res_memwb | input | DATA_W | Write data in memory/writeback |
| res_wbend | input | DATA_W | Write data in post-writeback latch |
| rf_a | input | DATA_W | Register file value for source A, read in decode |
| rf_b | input | DATA_W | Register file value for source B, read in decode |
| dec_dest | output | 4 | Destination tag of the decoding instruction |
| hz_class | output | 3 | Hazard class of the decoding instruction |
| stall | output | 1 | Hold fetch and decode this cycle |
| bubble_ex | output | 1 | Insert a bubble into execute at the next clock |
| ex_class | output | 3 | Registered hazard class for the execute stage |
| ex_pos_a | output | 2 | Registered forwarding position, operand A |
| ex_pos_b | output | 2 | Registered forwarding position, operand B |
| ex_opnd_a | output | DATA_W | Forwarded operand A |
| ex_opnd_b | output | DATA_W | Forwarded operand B |

## Verification
The assertions check several properties on every cycle:
- a stall only happens with a load in execute;
- a stall is always followed by a bubble with register-file positions and by a stall-free cycle;
- non-writing opcodes never produce a tag;
- a position-0 select always points back to a real decode/execute match.

Only the bench's scenarios can show the rest. That covers youngest-producer priority among several matching stages and the ignored B field of a load. It also covers the exact values routed from each of the four operand sources and the reset contents, which the bench compares on every cycle against its behavioural model.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;
    localparam int REG_W   = 3;
    localparam int TAG_W   = REG_W + 1;
    localparam int NO_TAG  = 1 << REG_W;
    localparam int INSTR_W = 25;
    localparam int OP_LSB  = 22;
    localparam int RA_LSB  = 19;
    localparam int RB_LSB  = 16;
    localparam int NSTAGE  = 3;
    localparam int POS_W   = $clog2(NSTAGE + 1);
    localparam logic [POS_W-1:0] POS_RF = '1;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_NAND = 3'd1,
        OP_LW   = 3'd2,
        OP_SW   = 3'd3,
        OP_BEQ  = 3'd4,
        OP_MULT = 3'd5,
        OP_HALT = 3'd6,
        OP_NOOP = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        HZ_NONE    = 3'd0,
        HZ_A       = 3'd1,
        HZ_B       = 3'd2,
        HZ_AB      = 3'd3,
        HZ_LOADUSE = 3'd4
    } hz_class_e;

    typedef enum logic {
        FL_RUN    = 1'b0,
        FL_BUBBLE = 1'b1
    } flow_e;
endpackage

// File: rtl/hz_decode.sv
`timescale 1ns/1ps
module hz_decode
    import hz_pkg::*;
(
    input  logic [2:0]       op_bits,
    input  logic [REG_W-1:0] rb_in,
    input  logic [REG_W-1:0] dst_lo,
    output logic             use_a,
    output logic             use_b,
    output logic [TAG_W-1:0] dest_tag
);
    op_e op;
    assign op = op_e'(op_bits);

    always_comb begin
        use_a    = 1'b1;
        use_b    = 1'b0;
        dest_tag = TAG_W'(NO_TAG);
        unique case (op)
            OP_ADD, OP_NAND, OP_MULT: begin
                use_b    = 1'b1;
                dest_tag = {1'b0, dst_lo};
            end
            OP_LW: begin
                dest_tag = {1'b0, rb_in};
            end
            OP_SW, OP_BEQ: begin
                use_b = 1'b1;
            end
            OP_HALT, OP_NOOP: begin
                use_a = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/hz_match.sv
`timescale 1ns/1ps
module hz_match #(
    parameter int NST  = 3,
    parameter int TW   = 4,
    parameter int PW   = 2
) (
    input  logic [TW-1:0]          src_tag,
    input  logic                   use_src,
    input  logic [NST-1:0][TW-1:0] stage_tags,
    output logic [PW-1:0]          pos,
    output logic                   hit
);
    // Scan oldest to youngest so the youngest matching stage is written last.
    always_comb begin
        pos = '1;
        for (int i = NST - 1; i >= 0; i--) begin
            if (use_src && (stage_tags[i] == src_tag)) begin
                pos = PW'(i);
            end
        end
    end

    assign hit = (pos != '1);
endmodule

// File: rtl/hz_opnd_mux.sv
`timescale 1ns/1ps
module hz_opnd_mux #(
    parameter int NST = 3,
    parameter int DW  = 32,
    parameter int PW  = 2
) (
    input  logic [PW-1:0]          pos,
    input  logic [DW-1:0]          rf_val,
    input  logic [NST-1:0][DW-1:0] results,
    output logic [DW-1:0]          opnd
);
    always_comb begin
        opnd = rf_val;
        for (int i = 0; i < NST; i++) begin
            if (pos == PW'(i)) begin
                opnd = results[i];
            end
        end
    end
endmodule

// File: rtl/hz_ctrl.sv
`timescale 1ns/1ps
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lu_raw,
    input  logic [2:0]                  dec_class,
    input  logic [1:0][POS_W-1:0]       dec_pos,
    input  logic [1:0][DATA_W-1:0]      rf_val,
    output logic                        stall,
    output logic [2:0]                  cur_class,
    output logic [2:0]                  ex_class,
    output logic [1:0][POS_W-1:0]       ex_pos,
    output logic [1:0][DATA_W-1:0]      ex_rf
);
    flow_e     state_q, state_nx;
    hz_class_e cls_now;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FL_RUN;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = FL_RUN;
        stall    = 1'b0;
        cls_now  = hz_class_e'(dec_class);
        unique case (state_q)
            FL_RUN: begin
                if (lu_raw) begin
                    stall    = 1'b1;
                    cls_now  = HZ_LOADUSE;
                    state_nx = FL_BUBBLE;
                end
            end
            FL_BUBBLE: begin
                state_nx = FL_RUN;
            end
        endcase
    end

    assign cur_class = cls_now;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_class <= HZ_NONE;
            ex_pos   <= {POS_RF, POS_RF};
            ex_rf    <= '0;
        end else begin
            ex_rf <= rf_val;
            if (stall) begin
                ex_class <= HZ_LOADUSE;
                ex_pos   <= {POS_RF, POS_RF};
            end else begin
                ex_class <= cls_now;
                ex_pos   <= dec_pos;
            end
        end
    end
endmodule

// File: rtl/hz_fwd_unit.sv
`timescale 1ns/1ps
module hz_fwd_unit
    import hz_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [24:0]       dec_instr,
    input  logic              ex_is_load,
    input  logic [3:0]        tag_idex,
    input  logic [3:0]        tag_exmem,
    input  logic [3:0]        tag_memwb,
    input  logic [DATA_W-1:0] res_exmem,
    input  logic [DATA_W-1:0] res_memwb,
    input  logic [DATA_W-1:0] res_wbend,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    output logic [3:0]        dec_dest,
    output logic [2:0]        hz_class,
    output logic              stall,
    output logic              bubble_ex,
    output logic [2:0]        ex_class,
    output logic [1:0]        ex_pos_a,
    output logic [1:0]        ex_pos_b,
    output logic [DATA_W-1:0] ex_opnd_a,
    output logic [DATA_W-1:0] ex_opnd_b
);
    localparam int NOPND = 2;

    logic                        use_a, use_b;
    logic [NOPND-1:0]            use_v;
    logic [NOPND-1:0][TAG_W-1:0] src_v;
    logic [NOPND-1:0][POS_W-1:0] pos_v;
    logic [NOPND-1:0]            hit_v;
    logic [NOPND-1:0][POS_W-1:0] ex_pos_v;
    logic [NOPND-1:0][DATA_W-1:0] ex_rf_v;
    logic [NOPND-1:0][DATA_W-1:0] opnd_v;
    logic [NSTAGE-1:0][TAG_W-1:0] tags;
    logic [NSTAGE-1:0][DATA_W-1:0] results;
    logic                        lu_raw;
    logic                        stall_i;
    wire                         unused_offset = ^dec_instr[15:3];

    assign tags    = {tag_memwb, tag_exmem, tag_idex};
    assign results = {res_wbend, res_memwb, res_exmem};

    hz_decode u_dec (
        .op_bits  (dec_instr[OP_LSB+2:OP_LSB]),
        .rb_in    (dec_instr[RB_LSB+REG_W-1:RB_LSB]),
        .dst_lo   (dec_instr[REG_W-1:0]),
        .use_a    (use_a),
        .use_b    (use_b),
        .dest_tag (dec_dest)
    );

    assign use_v = {use_b, use_a};
    assign src_v = {{1'b0, dec_instr[RB_LSB+REG_W-1:RB_LSB]},
                    {1'b0, dec_instr[RA_LSB+REG_W-1:RA_LSB]}};

    generate
        for (genvar g = 0; g < NOPND; g++) begin : g_opnd
            hz_match #(.NST(NSTAGE), .TW(TAG_W), .PW(POS_W)) u_match (
                .src_tag    (src_v[g]),
                .use_src    (use_v[g]),
                .stage_tags (tags),
                .pos        (pos_v[g]),
                .hit        (hit_v[g])
            );
            hz_opnd_mux #(.NST(NSTAGE), .DW(DATA_W), .PW(POS_W)) u_mux (
                .pos     (ex_pos_v[g]),
                .rf_val  (ex_rf_v[g]),
                .results (results),
                .opnd    (opnd_v[g])
            );
        end
    endgenerate

    // A match at position 0 is a match against the decode/execute tag.
    assign lu_raw = ex_is_load && ((pos_v[0] == POS_W'(0)) || (pos_v[1] == POS_W'(0)));

    hz_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .lu_raw    (lu_raw),
        .dec_class ({1'b0, hit_v[1], hit_v[0]}),
        .dec_pos   (pos_v),
        .rf_val    ({rf_b, rf_a}),
        .stall     (stall_i),
        .cur_class (hz_class),
        .ex_class  (ex_class),
        .ex_pos    (ex_pos_v),
        .ex_rf     (ex_rf_v)
    );

    assign stall     = stall_i;
    assign bubble_ex = stall_i;
    assign ex_pos_a  = ex_pos_v[0];
    assign ex_pos_b  = ex_pos_v[1];
    assign ex_opnd_a = opnd_v[0];
    assign ex_opnd_b = opnd_v[1];
endmodule

// File: rtl/hz_fwd_unit_chk.sv
`timescale 1ns/1ps
module hz_fwd_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [24:0] dec_instr,
    input logic        ex_is_load,
    input logic [3:0]  tag_idex,
    input logic [3:0]  dec_dest,
    input logic        stall,
    input logic [2:0]  ex_class,
    input logic [1:0]  ex_pos_a,
    input logic [1:0]  ex_pos_b
);
    // R7
    stall_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ex_is_load);

    // R7
    stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (ex_class == 3'd4 && ex_pos_a == 2'd3 && ex_pos_b == 2'd3));

    // R8
    single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R2
    no_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_instr[24:22] inside {3'd3, 3'd4, 3'd6, 3'd7}) |-> dec_dest == 4'd8);

    // R4
    pos0_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_pos_a == 2'd0) |-> ($past(tag_idex) == {1'b0, $past(dec_instr[21:19])}));
endmodule

bind hz_fwd_unit hz_fwd_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_instr  (dec_instr),
    .ex_is_load (ex_is_load),
    .tag_idex   (tag_idex),
    .dec_dest   (dec_dest),
    .stall      (stall),
    .ex_class   (ex_class),
    .ex_pos_a   (ex_pos_a),
    .ex_pos_b   (ex_pos_b)
);

// File: tb/hz_fwd_unit_tb.sv
`timescale 1ns/1ps
module hz_fwd_unit_tb;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [24:0]   dec_instr = 25'h1C00000;
    logic          ex_is_load = 1'b0;
    logic [3:0]    tag_idex = 4'd8, tag_exmem = 4'd8, tag_memwb = 4'd8;
    logic [DW-1:0] res_exmem = '0, res_memwb = '0, res_wbend = '0;
    logic [DW-1:0] rf_a = '0, rf_b = '0;
    logic [3:0]    dec_dest;
    logic [2:0]    hz_class, ex_class;
    logic          stall, bubble_ex;
    logic [1:0]    ex_pos_a, ex_pos_b;
    logic [DW-1:0] ex_opnd_a, ex_opnd_b;

    int n_chk = 0;
    int n_fail = 0;

    // model of execute-stage state
    bit           m_flow = 1'b1;
    int           m_cls = 0;
    int           m_pa = -1, m_pb = -1;
    logic [DW-1:0] m_rfa = '0, m_rfb = '0;

    always #4 clk = ~clk;

    hz_fwd_unit #(.DATA_W(DW)) u_dut (.*);

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int find_pos(bit u, int r, int te, int tm, int tw);
        if (!u) return -1;
        if (r == te) return 0;
        if (r == tm) return 1;
        if (r == tw) return 2;
        return -1;
    endfunction

    function automatic longint enc_pos(int p);
        return (p < 0) ? 3 : p;
    endfunction

    task automatic step(input string req, input int op, input int ra, input int rb, input int off,
                        input int te, input int tm, input int tw, input bit ld);
        bit ua, ub, lu;
        int pa, pb, cls, dst;
        logic [DW-1:0] exp_a, exp_b;
        @(negedge clk);
        dec_instr  = {3'(op), 3'(ra), 3'(rb), 16'(off)};
        tag_idex   = 4'(te);
        tag_exmem  = 4'(tm);
        tag_memwb  = 4'(tw);
        ex_is_load = ld;
        res_exmem  = $urandom;
        res_memwb  = $urandom;
        res_wbend  = $urandom;
        rf_a       = $urandom;
        rf_b       = $urandom;
        #1;
        ua  = (op != 6 && op != 7);
        ub  = (op == 0 || op == 1 || op == 3 || op == 4 || op == 5);
        pa  = find_pos(ua, ra, te, tm, tw);
        pb  = find_pos(ub, rb, te, tm, tw);
        lu  = m_flow && ld && (pa == 0 || pb == 0);
        cls = lu ? 4 : ((pb >= 0 ? 2 : 0) + (pa >= 0 ? 1 : 0));
        dst = (op == 0 || op == 1 || op == 5) ? (off & 7) : (op == 2) ? rb : 8;
        exp_a = (m_pa == 0) ? res_exmem : (m_pa == 1) ? res_memwb : (m_pa == 2) ? res_wbend : m_rfa;
        exp_b = (m_pb == 0) ? res_exmem : (m_pb == 1) ? res_memwb : (m_pb == 2) ? res_wbend : m_rfb;
        chk("R2", "dec_dest", dec_dest, dst);
        chk(req, "hz_class", hz_class, cls);
        chk(req, "stall", stall, lu);
        chk("R7", "bubble_ex", bubble_ex, lu);
        chk("R5", "ex_class", ex_class, m_cls);
        chk("R5", "ex_pos_a", ex_pos_a, enc_pos(m_pa));
        chk("R5", "ex_pos_b", ex_pos_b, enc_pos(m_pb));
        chk("R6", "ex_opnd_a", ex_opnd_a, exp_a);
        chk("R6", "ex_opnd_b", ex_opnd_b, exp_b);
        @(posedge clk);
        m_rfa = rf_a;
        m_rfb = rf_b;
        if (lu) begin
            m_flow = 1'b0; m_cls = 4; m_pa = -1; m_pb = -1;
        end else begin
            m_flow = 1'b1; m_cls = cls; m_pa = pa; m_pb = pb;
        end
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        chk("R9", "ex_class", ex_class, 0);
        chk("R9", "ex_pos_a", ex_pos_a, 3);
        chk("R9", "ex_pos_b", ex_pos_b, 3);
        chk("R9", "ex_opnd_a", ex_opnd_a, 0);
        chk("R9", "ex_opnd_b", ex_opnd_b, 0);
        chk("R9", "stall", stall, 0);

        // R1 source usage
        step("R1", 2, 1, 2, 0, 2, 8, 8, 0);
        step("R1", 6, 3, 3, 0, 3, 3, 3, 0);
        step("R1", 3, 0, 5, 0, 8, 5, 8, 0);
        step("R1", 7, 4, 4, 0, 4, 4, 4, 1);
        // R2 destination tags
        step("R2", 0, 1, 1, 5, 8, 8, 8, 0);
        step("R2", 2, 1, 6, 9, 8, 8, 8, 0);
        step("R2", 4, 1, 1, 3, 8, 8, 8, 0);
        step("R2", 5, 1, 1, 7, 8, 8, 8, 0);
        // R3 classes and the no-destination tag
        step("R3", 0, 1, 2, 0, 8, 8, 8, 0);
        step("R3", 0, 1, 2, 0, 1, 2, 8, 0);
        step("R3", 1, 4, 4, 0, 4, 8, 8, 0);
        step("R3", 0, 0, 0, 0, 8, 8, 8, 0);
        // R4 youngest producer wins
        step("R4", 0, 3, 5, 0, 3, 3, 3, 0);
        step("R4", 0, 3, 5, 0, 8, 3, 3, 0);
        step("R4", 0, 6, 5, 0, 1, 2, 5, 0);
        step("R4", 1, 2, 2, 0, 7, 2, 2, 0);
        step("R4", 0, 1, 1, 0, 8, 8, 8, 0);
        // R7 load-use on A, then R8 suppression in the bubble cycle
        step("R7", 0, 2, 6, 0, 2, 8, 8, 1);
        step("R8", 0, 2, 6, 0, 2, 8, 8, 1);
        step("R7", 3, 1, 4, 0, 4, 8, 8, 1);
        step("R8", 7, 0, 0, 0, 8, 4, 8, 0);
        step("R7", 0, 1, 2, 0, 3, 8, 8, 1);
        step("R7", 0, 1, 1, 0, 8, 8, 8, 1);
        step("R6", 0, 1, 2, 0, 8, 8, 8, 0);

        for (int i = 0; i < 600; i++) begin
            step("R6", int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 7)), int'($urandom_range(0, 65535)),
                 int'($urandom_range(0, 8)), int'($urandom_range(0, 8)),
                 int'($urandom_range(0, 8)), bit'($urandom_range(0, 1)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule